// File: doc/BRIEF.md
# Dual-Issue Hazard and Pairing Unit

This block makes the issue decision for a two-wide, in-order, statically scheduled pipeline that has full result bypassing. Each cycle it looks at the two instructions in decode and at the two instructions held in the decode/execute latch. It then decides which decode slots advance. Slot 0 is always the older instruction. Because bypassing covers every other case, the only data hazard that stalls is a source that needs the result of a load still in the latch. The block also checks the younger decode instruction against the destination of the older one, and it applies the pipe-pairing rule: one integer-pipe instruction and one floating-point-pipe instruction per cycle.

The pipeline is rigid. The younger instruction never issues unless the older one does, and nothing from the next group moves into a slot that is held. When a decode instruction does not issue, the block asks the front end to hold fetch and decode. It also flags which latch slots must receive a bubble. When only slot 0 goes, the block reports a split. The held younger instruction then becomes the older one on the next cycle. The decision is purely combinational on the current inputs.

Top module: `dual_issue_ctl`

## Requirements
- R1: A load-use hit on decode slot 0 blocks slot 0, and therefore slot 1 as well. A hit means either of its sources (rs1 or rs2) equals the destination of a latch slot that is valid, marked as a load, has its write enable set and has a non-zero destination.
- R2: A load-use hit on decode slot 1, under the same rule, blocks slot 1 only. Slot 0 may still issue.
- R3: Both latch slots are checked against both sources of both decode slots. Latch slot k uses bits [k*5 +: 5] of the destination vector, and decode slot k uses the same bit positions of its source and destination vectors.
- R4: These never cause a stall: register 0, a latch slot with valid low, a latch slot with write enable low, and a latch instruction that is not a load (its result is bypassed).
- R5: Suppose decode slot 1 reads the destination of decode slot 0, and slot 0's write enable is set with a non-zero destination. Then slot 1 is held and slot 0 may issue alone.
- R6: The pipe-class bit (0 = integer pipe, 1 = floating-point pipe) decides pairing. When both decode slots carry the same value, slot 1 is held.
- R7: Slot 1 issues only in a cycle where slot 0 issues. This includes the case where slot 0 is empty.
- R8: hold is high exactly when some valid decode slot does not issue.
- R9: bubble[k] is high exactly when issue[k] is low. split is high exactly when slot 0 issues while a valid slot 1 does not.
- R10: With no hazard and one instruction for each pipe, both valid slots issue in the same evaluation. A lone valid slot 0 with no hazard issues alone, without hold or split.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_valid | input | 2 | Decode slot holds an instruction (bit k = slot k) |
| dec_fp | input | 2 | Pipe class per decode slot, 1 = floating-point |
| dec_rs1 | input | 10 | First source register per decode slot |
| dec_rs2 | input | 10 | Second source register per decode slot |
| dec_rd | input | 10 | Destination register per decode slot |
| dec_rd_we | input | 2 | Decode slot writes its destination |
| dx_valid | input | 2 | Latch slot holds an instruction |
| dx_load | input | 2 | Latch slot instruction is a load |
| dx_rd | input | 10 | Destination register per latch slot |
| dx_rd_we | input | 2 | Latch slot writes its destination |
| issue | output | 2 | Decode slot advances this cycle |
| hold | output | 1 | Freeze fetch and decode |
| split | output | 1 | Slot 0 issues alone, slot 1 stays |
| bubble | output | 2 | Insert an empty entry into the latch slot |

## Verification
Every result is a combinational function of the inputs of the same cycle, so each result is due zero cycles after its stimulus. The bench applies each stimulus on the falling clock edge and compares the outputs a quarter period later, well before the next rising edge. No result is carried into the next cycle. Directed tasks cover each hazard source and latch slot separately, and a randomized sweep compares every output against a model in the bench that loops over sources and latch slots in its own way.

// File: rtl/dih_pkg.sv
package dih_pkg;
  localparam int NSLOT = 2;
  localparam int NSRC  = 2;
  typedef enum logic {PIPE_INT = 1'b0, PIPE_FP = 1'b1} pipe_e;
endpackage

// File: rtl/dih_src_cmp.sv
module dih_src_cmp #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] dst,
  input  logic             dst_live,
  output logic             hit
);
  function automatic logic reg_match(input logic [REG_W-1:0] s,
                                     input logic [REG_W-1:0] d,
                                     input logic live);
    return live && (d != '0) && (s == d);
  endfunction

  assign hit = reg_match(src, dst, dst_live);
endmodule

// File: rtl/dih_load_use.sv
module dih_load_use
  import dih_pkg::*;
#(
  parameter int REG_W = 5,
  localparam int VW = NSLOT * REG_W
) (
  input  logic [VW-1:0]    dec_rs1,
  input  logic [VW-1:0]    dec_rs2,
  input  logic [NSLOT-1:0] dx_valid,
  input  logic [NSLOT-1:0] dx_load,
  input  logic [VW-1:0]    dx_rd,
  input  logic [NSLOT-1:0] dx_rd_we,
  output logic [NSLOT-1:0] ld_hit
);
  logic [NSLOT-1:0] ld_live;
  assign ld_live = dx_valid & dx_load & dx_rd_we;

  for (genvar d = 0; d < NSLOT; d++) begin : g_dec
    logic [NSRC*NSLOT-1:0] hits;
    for (genvar s = 0; s < NSRC; s++) begin : g_src
      logic [REG_W-1:0] src;
      assign src = (s == 0) ? dec_rs1[d*REG_W +: REG_W] : dec_rs2[d*REG_W +: REG_W];
      for (genvar x = 0; x < NSLOT; x++) begin : g_dx
        dih_src_cmp #(.REG_W(REG_W)) u_cmp (
          .src     (src),
          .dst     (dx_rd[x*REG_W +: REG_W]),
          .dst_live(ld_live[x]),
          .hit     (hits[s*NSLOT + x])
        );
      end
    end
    assign ld_hit[d] = |hits;
  end
endmodule

// File: rtl/dih_pair_check.sv
module dih_pair_check
  import dih_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] young_rs1,
  input  logic [REG_W-1:0] young_rs2,
  input  logic [REG_W-1:0] old_rd,
  input  logic             old_rd_we,
  input  pipe_e            old_pipe,
  input  pipe_e            young_pipe,
  output logic             pair_dep,
  output logic             cls_clash
);
  logic dep_a, dep_b;

  dih_src_cmp #(.REG_W(REG_W)) u_dep_a (
    .src(young_rs1), .dst(old_rd), .dst_live(old_rd_we), .hit(dep_a)
  );
  dih_src_cmp #(.REG_W(REG_W)) u_dep_b (
    .src(young_rs2), .dst(old_rd), .dst_live(old_rd_we), .hit(dep_b)
  );

  assign pair_dep  = dep_a | dep_b;
  assign cls_clash = (old_pipe == young_pipe);
endmodule

// File: rtl/dih_issue_arb.sv
module dih_issue_arb
  import dih_pkg::*;
(
  input  logic [NSLOT-1:0] dec_valid,
  input  logic [NSLOT-1:0] ld_hit,
  input  logic             pair_dep,
  input  logic             cls_clash,
  output logic [NSLOT-1:0] issue,
  output logic             hold,
  output logic             split,
  output logic [NSLOT-1:0] bubble
);
  logic young_block;

  always_comb begin
    issue[0]    = dec_valid[0] & ~ld_hit[0];
    young_block = ~issue[0] | ld_hit[1] | pair_dep | cls_clash;
    issue[1]    = dec_valid[1] & ~young_block;
  end

  assign hold   = |(dec_valid & ~issue);
  assign split  = issue[0] & dec_valid[1] & ~issue[1];
  assign bubble = ~issue;
endmodule

// File: rtl/dual_issue_ctl.sv
module dual_issue_ctl
  import dih_pkg::*;
#(
  parameter int REG_W = 5,
  localparam int VW = NSLOT * REG_W
) (
  input  logic [NSLOT-1:0] dec_valid,
  input  logic [NSLOT-1:0] dec_fp,
  input  logic [VW-1:0]    dec_rs1,
  input  logic [VW-1:0]    dec_rs2,
  input  logic [VW-1:0]    dec_rd,
  input  logic [NSLOT-1:0] dec_rd_we,
  input  logic [NSLOT-1:0] dx_valid,
  input  logic [NSLOT-1:0] dx_load,
  input  logic [VW-1:0]    dx_rd,
  input  logic [NSLOT-1:0] dx_rd_we,
  output logic [NSLOT-1:0] issue,
  output logic             hold,
  output logic             split,
  output logic [NSLOT-1:0] bubble
);
  logic [NSLOT-1:0] ld_hit;
  logic             pair_dep;
  logic             cls_clash;

  dih_load_use #(.REG_W(REG_W)) u_load_use (
    .dec_rs1 (dec_rs1),
    .dec_rs2 (dec_rs2),
    .dx_valid(dx_valid),
    .dx_load (dx_load),
    .dx_rd   (dx_rd),
    .dx_rd_we(dx_rd_we),
    .ld_hit  (ld_hit)
  );

  dih_pair_check #(.REG_W(REG_W)) u_pair (
    .young_rs1 (dec_rs1[REG_W +: REG_W]),
    .young_rs2 (dec_rs2[REG_W +: REG_W]),
    .old_rd    (dec_rd[0 +: REG_W]),
    .old_rd_we (dec_rd_we[0]),
    .old_pipe  (pipe_e'(dec_fp[0])),
    .young_pipe(pipe_e'(dec_fp[1])),
    .pair_dep  (pair_dep),
    .cls_clash (cls_clash)
  );

  dih_issue_arb u_arb (
    .dec_valid(dec_valid),
    .ld_hit   (ld_hit),
    .pair_dep (pair_dep),
    .cls_clash(cls_clash),
    .issue    (issue),
    .hold     (hold),
    .split    (split),
    .bubble   (bubble)
  );
endmodule

// File: rtl/dual_issue_ctl_chk.sv
module dual_issue_ctl_chk (
  input logic [1:0] dec_valid,
  input logic [1:0] ld_hit,
  input logic       pair_dep,
  input logic       cls_clash,
  input logic [1:0] issue,
  input logic       hold,
  input logic       split,
  input logic [1:0] bubble
);
  always_comb begin
    p_slot0_load_r1: assert (!(ld_hit[0] && issue[0]));
    p_slot1_load_r2: assert (!(ld_hit[1] && issue[1]));
    p_intra_dep_r5:  assert (!(pair_dep && issue[1]));
    p_pairing_r6:    assert (!(cls_clash && issue[1]));
    p_rigid_r7:      assert (!(issue[1] && !issue[0]));
    p_hold_need_r8:  assert (!hold || ((dec_valid & ~issue) != 2'b00));
    p_hold_free_r8:  assert (hold || ((dec_valid & ~issue) == 2'b00));
    p_bubble_r9:     assert ((bubble & issue) == 2'b00);
    p_split_r9:      assert (!split || (issue == 2'b01));
    p_clean_r10:     assert (!(dec_valid[0] && !ld_hit[0]) || issue[0]);
  end
endmodule

bind dual_issue_ctl dual_issue_ctl_chk u_chk (
  .dec_valid(dec_valid),
  .ld_hit   (ld_hit),
  .pair_dep (pair_dep),
  .cls_clash(cls_clash),
  .issue    (issue),
  .hold     (hold),
  .split    (split),
  .bubble   (bubble)
);

// File: tb/dual_issue_ctl_tb.sv
module dual_issue_ctl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [1:0]      dec_valid, dec_fp, dec_rd_we, dx_valid, dx_load, dx_rd_we;
  logic [2*RW-1:0] dec_rs1, dec_rs2, dec_rd, dx_rd;
  logic [1:0]      issue, bubble;
  logic            hold, split;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  dual_issue_ctl #(.REG_W(RW)) u_dut (
    .dec_valid(dec_valid), .dec_fp(dec_fp), .dec_rs1(dec_rs1), .dec_rs2(dec_rs2),
    .dec_rd(dec_rd), .dec_rd_we(dec_rd_we), .dx_valid(dx_valid), .dx_load(dx_load),
    .dx_rd(dx_rd), .dx_rd_we(dx_rd_we), .issue(issue), .hold(hold),
    .split(split), .bubble(bubble)
  );

  task automatic clear_all();
    dec_valid = '0; dec_fp = '0; dec_rs1 = '0; dec_rs2 = '0; dec_rd = '0; dec_rd_we = '0;
    dx_valid = '0; dx_load = '0; dx_rd = '0; dx_rd_we = '0;
  endtask

  // slot 0 integer, slot 1 floating-point, distinct registers, no hazard
  task automatic base_pair();
    clear_all();
    dec_valid = 2'b11; dec_fp = 2'b10; dec_rd_we = 2'b11;
    dec_rs1 = {5'd11, 5'd1}; dec_rs2 = {5'd12, 5'd2}; dec_rd = {5'd13, 5'd3};
    dx_valid = 2'b11; dx_rd_we = 2'b11; dx_rd = {5'd21, 5'd20};
  endtask

  task automatic expect_out(input string req, input logic [1:0] e_issue,
                            input logic e_hold, input logic e_split, input logic [1:0] e_bub);
    #(CLK_PERIOD/4);
    n_checks++;
    if (issue !== e_issue || hold !== e_hold || split !== e_split || bubble !== e_bub) begin
      n_fail++;
      $display("FAIL %s: issue=%b hold=%b split=%b bubble=%b expected issue=%b hold=%b split=%b bubble=%b",
               req, issue, hold, split, bubble, e_issue, e_hold, e_split, e_bub);
    end
  endtask

  task automatic t_idle();
    @(negedge clk); clear_all();
    expect_out("R9 idle", 2'b00, 1'b0, 1'b0, 2'b11);
  endtask

  task automatic t_free_pair();
    @(negedge clk); base_pair();
    dx_rd = {5'd11, 5'd1}; // non-load producers are bypassed
    expect_out("R10 R4 free pair", 2'b11, 1'b0, 1'b0, 2'b00);
    @(negedge clk); base_pair(); dec_valid = 2'b01;
    expect_out("R10 lone slot0", 2'b01, 1'b0, 1'b0, 2'b10);
  endtask

  task automatic t_slot0_load();
    @(negedge clk); base_pair();
    dx_load = 2'b10; dx_rd = {5'd2, 5'd20};  // latch slot1 load feeds slot0 rs2
    expect_out("R1 R3 slot0 vs dx1", 2'b00, 1'b1, 1'b0, 2'b11);
    @(negedge clk); base_pair();
    dx_load = 2'b01; dx_rd = {5'd21, 5'd1};  // latch slot0 load feeds slot0 rs1
    expect_out("R1 R7 slot0 vs dx0", 2'b00, 1'b1, 1'b0, 2'b11);
  endtask

  task automatic t_slot1_load();
    @(negedge clk); base_pair();
    dx_load = 2'b01; dx_rd = {5'd21, 5'd11};
    expect_out("R2 slot1 vs dx0", 2'b01, 1'b1, 1'b1, 2'b10);
    @(negedge clk); base_pair();
    dx_load = 2'b10; dx_rd = {5'd12, 5'd20};
    expect_out("R2 R3 slot1 vs dx1", 2'b01, 1'b1, 1'b1, 2'b10);
  endtask

  task automatic t_no_match();
    @(negedge clk); base_pair();
    dec_rs1 = {5'd11, 5'd0}; dx_load = 2'b11; dx_rd = {5'd21, 5'd0};
    expect_out("R4 register 0", 2'b11, 1'b0, 1'b0, 2'b00);
    @(negedge clk); base_pair();
    dx_load = 2'b11; dx_rd = {5'd11, 5'd1}; dx_valid = 2'b00;
    expect_out("R4 latch invalid", 2'b11, 1'b0, 1'b0, 2'b00);
    @(negedge clk); base_pair();
    dx_load = 2'b11; dx_rd = {5'd11, 5'd1}; dx_rd_we = 2'b00;
    expect_out("R4 latch no write", 2'b11, 1'b0, 1'b0, 2'b00);
  endtask

  task automatic t_intra_pair();
    @(negedge clk); base_pair();
    dec_rs2 = {5'd3, 5'd2};
    expect_out("R5 intra dep", 2'b01, 1'b1, 1'b1, 2'b10);
    @(negedge clk); base_pair();
    dec_rs1 = {5'd3, 5'd1}; dec_rd_we = 2'b10;
    expect_out("R5 old no write", 2'b11, 1'b0, 1'b0, 2'b00);
    @(negedge clk); base_pair();
    dec_rd = {5'd13, 5'd0}; dec_rs1 = {5'd0, 5'd1};
    expect_out("R5 old rd zero", 2'b11, 1'b0, 1'b0, 2'b00);
  endtask

  task automatic t_pairing();
    @(negedge clk); base_pair(); dec_fp = 2'b00;
    expect_out("R6 two integer", 2'b01, 1'b1, 1'b1, 2'b10);
    @(negedge clk); base_pair(); dec_fp = 2'b11;
    expect_out("R6 two fp", 2'b01, 1'b1, 1'b1, 2'b10);
    @(negedge clk); base_pair(); dec_fp = 2'b01;
    expect_out("R6 fp then int", 2'b11, 1'b0, 1'b0, 2'b00);
  endtask

  task automatic t_rigid();
    @(negedge clk); base_pair(); dec_valid = 2'b10;
    expect_out("R7 R8 slot0 empty", 2'b00, 1'b1, 1'b0, 2'b11);
  endtask

  function automatic logic [5:0] model();
    logic [1:0] ld;
    logic dep, ok0, ok1;
    for (int d = 0; d < 2; d++) begin
      ld[d] = 1'b0;
      for (int x = 0; x < 2; x++) begin
        logic [RW-1:0] r;
        r = dx_rd[x*RW +: RW];
        if (dx_valid[x] && dx_load[x] && dx_rd_we[x] && r != 0 &&
            (dec_rs1[d*RW +: RW] == r || dec_rs2[d*RW +: RW] == r))
          ld[d] = 1'b1;
      end
    end
    dep = dec_rd_we[0] && dec_rd[RW-1:0] != 0 &&
          (dec_rs1[2*RW-1:RW] == dec_rd[RW-1:0] || dec_rs2[2*RW-1:RW] == dec_rd[RW-1:0]);
    ok0 = dec_valid[0] && !ld[0];
    ok1 = dec_valid[1] && ok0 && !ld[1] && !dep && (dec_fp[0] != dec_fp[1]);
    return {!ok1, !ok0,
            ok0 && dec_valid[1] && !ok1,
            (dec_valid[0] && !ok0) || (dec_valid[1] && !ok1),
            ok1, ok0};
  endfunction

  task automatic t_sweep();
    for (int i = 0; i < 300; i++) begin
      logic [5:0] m;
      @(negedge clk);
      dec_valid = 2'($urandom); dec_fp = 2'($urandom); dec_rd_we = 2'($urandom);
      dx_valid = 2'($urandom); dx_load = 2'($urandom); dx_rd_we = 2'($urandom);
      dec_rs1 = {2'($urandom), 2'($urandom)} == 0 ? '0 : {3'd0, 2'($urandom), 3'd0, 2'($urandom)};
      dec_rs2 = {3'd0, 2'($urandom), 3'd0, 2'($urandom)};
      dec_rd  = {3'd0, 2'($urandom), 3'd0, 2'($urandom)};
      dx_rd   = {3'd0, 2'($urandom), 3'd0, 2'($urandom)};
      m = model();
      expect_out("R1 R2 R5 R6 R8 R9 sweep", m[1:0], m[2], m[3], m[5:4]);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    clear_all();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_free_pair();
    t_slot0_load();
    t_slot1_load();
    t_no_match();
    t_intra_pair();
    t_pairing();
    t_rigid();
    t_sweep();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule